// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block collects the interrupt requests of a small CPU and decides which one is serviced. It has thirteen maskable sources and one software trap, fourteen in total. Each maskable source has an enable bit and a pending bit. A pending bit is set by a one-cycle event pulse from its source. A global enable gates all maskable requests. The software trap is always on and cannot be masked. Its pending flag cannot be read or written by software. Whenever any request is recognised, the block raises a common request line. That line makes the CPU branch to the fixed address 00FFh, where a vector instruction is placed.

When the vector instruction executes, the CPU pulses a strobe. One cycle later the block answers with an even byte offset between E0h and FEh, which indexes a table of two-byte vectors. The offset selects the highest-priority active source. The trap owns FEh, the top entry, whose two bytes are read high byte first. Maskable source k owns FCh − 2·k, so priority falls as the offset falls. When nothing is active, the answer is the default entry E0h.

Software writes the enable word, the pending word and the global enable through a small register-write port. Taking an interrupt clears the global enable. A return-from-interrupt strobe sets it again and retires a pending trap.

Top module: `intarb_top`

## Requirements
- R1: After synchronous active-low reset, the enables, the pending bits and the global enable are all 0. The request line is 0, vec_valid is 0 and vec_offset is E0h.
- R2: An irq_event pulse on bit k sets pending bit k in the next cycle. If a software write to the pending word lands in the same cycle, the event still sets its bit.
- R3: A write with wr_sel=0 loads the enable word from wr_data. wr_sel=1 loads the pending word. wr_sel=2 loads the global enable from wr_data bit 0. wr_sel=3 changes nothing.
- R4: irq_out is 1 exactly when the trap is pending, or when the global enable is 1 and at least one source is both enabled and pending. It follows register state in the same cycle.
- R5: A trap_req pulse raises irq_out from the next cycle, whatever the global enable and the enables are. It leaves pend_o unchanged. A reti pulse retires the trap, except in a cycle where trap_req is also high.
- R6: int_ack clears the global enable in the next cycle, and reti sets it. When both arrive in one cycle, int_ack wins. int_ack also wins over a software write.
- R7: A vis_req pulse gives vec_valid=1 for exactly one cycle, in the next cycle. vec_offset then holds FEh if the trap is pending. Otherwise it holds FCh − 2·k for the lowest index k that is both enabled and pending, and E0h if there is none. The global enable plays no part in this choice.
- R8: vec_offset keeps its value until the next vis_req.
- R9: A pending source whose enable bit is 0 neither raises irq_out nor changes the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_event | input | NUM_MASK | One-cycle condition pulses, one per maskable source |
| trap_req | input | 1 | Software trap strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 enables, 1 pending, 2 global enable, 3 none |
| wr_data | input | NUM_MASK | Write data |
| int_ack | input | 1 | CPU has taken the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| vis_req | input | 1 | Vector instruction strobe |
| irq_out | output | 1 | Common interrupt request |
| vec_valid | output | 1 | Vector answer valid, one cycle |
| vec_offset | output | 8 | Even vector table offset |
| en_o | output | NUM_MASK | Enable word |
| pend_o | output | NUM_MASK | Pending word |
| gie_o | output | 1 | Global enable |

## Verification
Two things can try to change the same state bit in one cycle, and the bench provokes both cases. In the first, a source event arrives in the same cycle as a software write of zero to the pending word. The bench then checks that the event's bit survives and all other bits clear. In the second, the global enable receives int_ack together with reti, and separately together with a software write. The trap flag likewise receives trap_req together with reti. In each of these cases the bench judges the outcome from the visible global enable and from irq_out in the following cycle.

// File: rtl/intarb_pkg.sv
// Shared constants, write-target codes and the offset mapping of the arbiter.
// Assumes the vector table spans E0h..FEh in steps of two bytes.
package intarb_pkg;
    localparam int NUM_MASK_DEF = 13;
    localparam int VEC_W        = 8;
    localparam logic [VEC_W-1:0] VEC_DEFAULT = 8'hE0;
    localparam logic [VEC_W-1:0] VEC_TRAP    = 8'hFE;

    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_PENDING = 2'd1,
        SEL_GLOBAL  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // Offset of maskable source idx: the slot just below the trap, descending.
    function automatic logic [VEC_W-1:0] slot_offset(input int unsigned idx);
        return VEC_TRAP - VEC_W'(2 * (idx + 1));
    endfunction
endpackage

// File: rtl/intarb_regs.sv
// Enable and pending words of the maskable sources.
// Assumes events are single-cycle pulses. An event wins over a same-cycle pending write.
module intarb_regs #(
    parameter int N = intarb_pkg::NUM_MASK_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  intarb_pkg::reg_sel_e  wr_sel,
    input  logic [N-1:0]          wr_data,
    input  logic [N-1:0]          irq_event,
    output logic [N-1:0]          en_q,
    output logic [N-1:0]          pend_q
);
    import intarb_pkg::*;

    logic wr_en_word;
    logic wr_pend_word;
    logic [N-1:0] pend_base;

    // Decode which word the write port targets.
    always_comb begin
        wr_en_word   = wr_en && (wr_sel == SEL_ENABLE);
        wr_pend_word = wr_en && (wr_sel == SEL_PENDING);
    end

    // Software value for the pending word before events are merged in.
    always_comb pend_base = wr_pend_word ? wr_data : pend_q;

    // Enable word register.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= '0;
        else if (wr_en_word) en_q <= wr_data;
    end

    // Pending word register, one flop per source.
    for (genvar g = 0; g < N; g++) begin : g_pend
        // Set by its event, otherwise follows software.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= pend_base[g] | irq_event[g];
        end
    end
endmodule

// File: rtl/intarb_ctrl.sv
// Global enable and the hidden trap flag.
// Precedence on the global enable: ack, then return, then a write.
// Precedence on the trap flag: a new trap wins over a return.
module intarb_ctrl (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  intarb_pkg::reg_sel_e wr_sel,
    input  logic                 wr_bit,
    input  logic                 int_ack,
    input  logic                 reti,
    input  logic                 trap_req,
    output logic                 gie_q,
    output logic                 trap_q
);
    import intarb_pkg::*;

    logic wr_gie;

    // Decode a write to the global enable.
    always_comb wr_gie = wr_en && (wr_sel == SEL_GLOBAL);

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (int_ack) gie_q <= 1'b0;
        else if (reti)    gie_q <= 1'b1;
        else if (wr_gie)  gie_q <= wr_bit;
    end

    // Trap flag, invisible to software.
    always_ff @(posedge clk) begin
        if (!rst_n)        trap_q <= 1'b0;
        else if (trap_req) trap_q <= 1'b1;
        else if (reti)     trap_q <= 1'b0;
    end
endmodule

// File: rtl/intarb_prio.sv
// Combinational priority encoder: trap first, then the lowest source index.
// Assumes N <= 14 so every slot stays at or above E2h.
module intarb_prio #(
    parameter int N = intarb_pkg::NUM_MASK_DEF
) (
    input  logic                          trap,
    input  logic [N-1:0]                  active,
    output logic [intarb_pkg::VEC_W-1:0]  offset
);
    import intarb_pkg::*;

    // Scan from the lowest priority up so that the highest active source is written last.
    always_comb begin
        offset = VEC_DEFAULT;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) offset = slot_offset(i);
        end
        if (trap) offset = VEC_TRAP;
    end
endmodule

// File: rtl/intarb_top.sv
// Vectored interrupt arbiter top level: state, request line and vector register.
// Assumes the CPU pulses int_ack, reti and vis_req for one cycle each.
module intarb_top #(
    parameter int NUM_MASK = intarb_pkg::NUM_MASK_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MASK-1:0] irq_event,
    input  logic                trap_req,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [NUM_MASK-1:0] wr_data,
    input  logic                int_ack,
    input  logic                reti,
    input  logic                vis_req,
    output logic                irq_out,
    output logic                vec_valid,
    output logic [7:0]          vec_offset,
    output logic [NUM_MASK-1:0] en_o,
    output logic [NUM_MASK-1:0] pend_o,
    output logic                gie_o
);
    import intarb_pkg::*;

    reg_sel_e            sel;
    logic [NUM_MASK-1:0] en_q;
    logic [NUM_MASK-1:0] pend_q;
    logic [NUM_MASK-1:0] active;
    logic                gie_q;
    logic                trap_q;
    logic [VEC_W-1:0]    arb_offset;
    logic [VEC_W-1:0]    vec_q;
    logic                valid_q;

    // Turn the raw select into the enum type.
    always_comb sel = reg_sel_e'(wr_sel);

    intarb_regs #(.N(NUM_MASK)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (sel),
        .wr_data   (wr_data),
        .irq_event (irq_event),
        .en_q      (en_q),
        .pend_q    (pend_q)
    );

    intarb_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_bit   (wr_data[0]),
        .int_ack  (int_ack),
        .reti     (reti),
        .trap_req (trap_req),
        .gie_q    (gie_q),
        .trap_q   (trap_q)
    );

    // A source counts as active when it is both enabled and pending.
    always_comb active = en_q & pend_q;

    intarb_prio #(.N(NUM_MASK)) i_prio (
        .trap   (trap_q),
        .active (active),
        .offset (arb_offset)
    );

    // Vector register: captures the answer on the strobe and keeps it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= VEC_DEFAULT;
            valid_q <= 1'b0;
        end else begin
            valid_q <= vis_req;
            if (vis_req) vec_q <= arb_offset;
        end
    end

    // Request line: the trap, or any gated maskable source.
    always_comb irq_out = trap_q | (gie_q & (|active));

    // Drive the visible state.
    always_comb begin
        vec_offset = vec_q;
        vec_valid  = valid_q;
        en_o       = en_q;
        pend_o     = pend_q;
        gie_o      = gie_q;
    end
endmodule

// File: rtl/intarb_chk.sv
// Temporal checks on the arbiter's ports. It is attached to every instance of the top.
module intarb_chk #(
    parameter int NUM_MASK = intarb_pkg::NUM_MASK_DEF
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_MASK-1:0] irq_event,
    input logic                trap_req,
    input logic                int_ack,
    input logic                vis_req,
    input logic                irq_out,
    input logic                vec_valid,
    input logic [7:0]          vec_offset,
    input logic [NUM_MASK-1:0] en_o,
    input logic [NUM_MASK-1:0] pend_o,
    input logic                gie_o
);
    assert_event_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_event) |=> ((pend_o & $past(irq_event)) == $past(irq_event)));

    assert_gated_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_o && |(en_o & pend_o)) |-> irq_out);

    assert_trap_raises_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> irq_out);

    assert_ack_clears_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !gie_o);

    assert_vector_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vis_req |=> (vec_valid && !vec_offset[0] && (vec_offset >= 8'hE0)));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_req |=> !vec_valid);

    assert_vector_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_req |=> $stable(vec_offset));
endmodule

bind intarb_top intarb_chk #(.NUM_MASK(NUM_MASK)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_event  (irq_event),
    .trap_req   (trap_req),
    .int_ack    (int_ack),
    .vis_req    (vis_req),
    .irq_out    (irq_out),
    .vec_valid  (vec_valid),
    .vec_offset (vec_offset),
    .en_o       (en_o),
    .pend_o     (pend_o),
    .gie_o      (gie_o)
);

// File: tb/test_intarb_top.sv
// Directed bench for the arbiter: one task per scenario, each checking its own results.
module test_intarb_top;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_event = '0;
    logic         trap_req = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic         int_ack = 1'b0;
    logic         reti = 1'b0;
    logic         vis_req = 1'b0;
    logic         irq_out;
    logic         vec_valid;
    logic [7:0]   vec_offset;
    logic [N-1:0] en_o;
    logic [N-1:0] pend_o;
    logic         gie_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    intarb_top #(.NUM_MASK(N)) i_intarb_top (
        .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .trap_req(trap_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .int_ack(int_ack),
        .reti(reti), .vis_req(vis_req), .irq_out(irq_out), .vec_valid(vec_valid),
        .vec_offset(vec_offset), .en_o(en_o), .pend_o(pend_o), .gie_o(gie_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference vector choice, written from the requirement text.
    function automatic logic [7:0] ref_vec(input logic trap, input logic [N-1:0] en,
                                           input logic [N-1:0] pend);
        if (trap) return 8'hFE;
        for (int k = 0; k < N; k++) if (en[k] && pend[k]) return 8'(8'hFC - 2 * k);
        return 8'hE0;
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [N-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ask_vector(input string req, input logic [7:0] exp);
        vis_req = 1'b1;
        step();
        vis_req = 1'b0;
        check({req, " valid"}, 32'(vec_valid), 32'd1);
        check({req, " offset"}, 32'(vec_offset), 32'(exp));
        step();
        check("R7 valid drops", 32'(vec_valid), 32'd0);
        check("R8 offset held", 32'(vec_offset), 32'(exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        check("R1 en", 32'(en_o), 0);
        check("R1 pend", 32'(pend_o), 0);
        check("R1 gie", 32'(gie_o), 0);
        check("R1 irq", 32'(irq_out), 0);
        check("R1 valid", 32'(vec_valid), 0);
        check("R1 offset", 32'(vec_offset), 32'hE0);
    endtask

    task automatic t_events();
        irq_event = 13'h0408;
        step();
        irq_event = '0;
        check("R2 event sets pending", 32'(pend_o), 32'h0408);
        check("R4 no request without gie", 32'(irq_out), 0);
    endtask

    task automatic t_writes();
        write_reg(2'd0, 13'h0408);
        check("R3 enable write", 32'(en_o), 32'h0408);
        write_reg(2'd2, 13'h0001);
        check("R3 gie write", 32'(gie_o), 1);
        check("R4 request with gie", 32'(irq_out), 1);
        write_reg(2'd3, 13'h1FFF);
        check("R3 sel3 en", 32'(en_o), 32'h0408);
        check("R3 sel3 pend", 32'(pend_o), 32'h0408);
        write_reg(2'd1, 13'h0000);
        check("R3 pending write", 32'(pend_o), 0);
        check("R4 request drops", 32'(irq_out), 0);
    endtask

    task automatic t_vector();
        write_reg(2'd1, 13'h0408);
        ask_vector("R7 highest of two", ref_vec(1'b0, 13'h0408, 13'h0408));
        write_reg(2'd0, 13'h0400);
        write_reg(2'd1, 13'h0409);
        ask_vector("R9 masked source skipped", 8'hE8);
        write_reg(2'd0, 13'h0001);
        write_reg(2'd1, 13'h0400);
        check("R9 masked pending no request", 32'(irq_out), 0);
        ask_vector("R9 default when masked", 8'hE0);
        write_reg(2'd0, 13'h1FFF);
        write_reg(2'd1, 13'h1000);
        ask_vector("R7 lowest slot", 8'hE4);
        write_reg(2'd1, 13'h1001);
        ask_vector("R7 top maskable", 8'hFC);
        write_reg(2'd2, 13'h0000);
        ask_vector("R7 gie ignored", 8'hFC);
        write_reg(2'd0, 13'h0000);
        ask_vector("R7 none active", 8'hE0);
        write_reg(2'd1, 13'h0000);
    endtask

    task automatic t_trap();
        trap_req = 1'b1;
        step();
        trap_req = 1'b0;
        check("R5 trap request", 32'(irq_out), 1);
        check("R5 pending unchanged", 32'(pend_o), 0);
        write_reg(2'd0, 13'h0010);
        write_reg(2'd1, 13'h0010);
        ask_vector("R5 trap vector", 8'hFE);
        trap_req = 1'b1; reti = 1'b1;
        step();
        trap_req = 1'b0; reti = 1'b0;
        check("R5 trap beats reti", 32'(irq_out), 1);
        write_reg(2'd0, 13'h0000);
        reti = 1'b1;
        step();
        reti = 1'b0;
        check("R5 reti retires trap", 32'(irq_out), 0);
        check("R6 reti sets gie", 32'(gie_o), 1);
        ask_vector("R5 after retire", 8'hE0);
        write_reg(2'd1, 13'h0000);
    endtask

    task automatic t_ack();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R6 ack clears gie", 32'(gie_o), 0);
        int_ack = 1'b1; reti = 1'b1;
        step();
        int_ack = 1'b0; reti = 1'b0;
        check("R6 ack beats reti", 32'(gie_o), 0);
        int_ack = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 13'h0001;
        step();
        int_ack = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R6 ack beats write", 32'(gie_o), 0);
    endtask

    task automatic t_collide();
        write_reg(2'd1, 13'h1FFF);
        irq_event = 13'h0020; wr_en = 1'b1; wr_sel = 2'd1; wr_data = '0;
        step();
        irq_event = '0; wr_en = 1'b0;
        check("R2 event beats pending write", 32'(pend_o), 32'h0020);
    endtask

    initial begin
        t_reset();
        t_events();
        t_writes();
        t_vector();
        t_trap();
        t_ack();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule